// File: doc/BRIEF.md
# Back-Channel CRC Error Recorder

This block sits on the transmit side of a serial link and counts CRC errors that the back-channel receiver reports. One strobe arrives per received frame that failed its CRC. The block holds two saturating counters. The functional counter records errors during normal operation. The self-test counter records errors only while the link is running its built-in self-test.

A strobe is counted only when link detect shows that the back-channel stream is locked. The self-test counter is cleared when self-test starts. After self-test ends, it keeps the result of the last run. The functional counter starts counting again as soon as self-test ends.

Software reads either counter through a small read port. Reading the functional counter with the read enable set clears it. Reading the self-test counter never clears it.

Top module: `bcrec_top`

## Requirements
- R1: After the asynchronous reset both counters read 0.
- R2: A CRC-error strobe that arrives while `link_det_i` is low changes neither counter.
- R3: The functional counter increments by one for each strobe taken while `link_det_i` is high and `bist_en_i` is low. It does not change while `bist_en_i` is high.
- R4: The self-test counter increments by one for each strobe taken while `link_det_i` and `bist_en_i` are both high.
- R5: In the first cycle in which `bist_en_i` is high, the self-test counter is reset. After that edge it reads 0, or it reads 1 if a counted strobe arrived in that same cycle.
- R6: While `bist_en_i` is low, the self-test counter holds its last value.
- R7: Both counters are 8 bits wide and saturate at 255 instead of wrapping.
- R8: `rd_data_o` shows the selected counter combinationally. `rd_sel_i` = 0 selects the functional counter and `rd_sel_i` = 1 selects the self-test counter.
- R9: If `rd_en_i` is high with `rd_sel_i` = 0, the functional counter clears at that clock edge. A counted strobe in the same cycle leaves it at 1.
- R10: If `rd_en_i` is high with `rd_sel_i` = 1, the self-test counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc_err_i | input | 1 | One-cycle strobe for each frame with a CRC error |
| link_det_i | input | 1 | Back-channel link detect (stream locked) |
| bist_en_i | input | 1 | High while the self-test mode is active |
| rd_en_i | input | 1 | Read strobe; clears the functional counter when it is selected |
| rd_sel_i | input | 1 | Counter select: 0 functional, 1 self-test |
| rd_data_o | output | 8 | Value of the selected counter |

## Verification
Strobes are applied in runs under each combination of link detect and mode, and the two counters are compared. This shows whether a count went to the wrong counter, or whether a count was taken while the link was down.

Three cases target the cycle-level corners:
- a strobe in the same cycle as self-test entry;
- a strobe in the same cycle as a clearing read;
- a second entry with no strobe.

These cases separate clear priority from lost counts. Runs of 300 strobes in each mode check that the counters stop at 255 and do not wrap.

// File: rtl/bcrec_pkg.sv
package bcrec_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned NUM_CNT  = 2;
  localparam int unsigned IDX_FUNC = 0;
  localparam int unsigned IDX_BIST = 1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/bcrec_mode_tracker.sv
module bcrec_mode_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bist_en_i,
  output logic bist_entry_o
);
  logic bist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bist_q <= 1'b0;
    else         bist_q <= bist_en_i;
  end

  assign bist_entry_o = bist_en_i & ~bist_q;

  AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bist_entry_o |=> !bist_entry_o); // R5
endmodule

// File: rtl/bcrec_sat_counter.sv
module bcrec_sat_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;

  // clear wins over the old value, but a same-cycle increment still lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= inc_i ? ONE : '0;
    else if (inc_i && cnt_q != MAX_VAL) cnt_q <= cnt_q + ONE;
  end

  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_VAL && !clr_i) |=> cnt_q == MAX_VAL); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/bcrec_top.sv
module bcrec_top
  import bcrec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             crc_err_i,
  input  logic             link_det_i,
  input  logic             bist_en_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic               bist_entry;
  logic               err_valid;
  logic [NUM_CNT-1:0] cnt_clr;
  logic [NUM_CNT-1:0] cnt_inc;
  cnt_t               cnt [NUM_CNT];

  bcrec_mode_tracker u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bist_en_i    (bist_en_i),
    .bist_entry_o (bist_entry)
  );

  assign err_valid = crc_err_i & link_det_i;

  always_comb begin
    cnt_inc           = '0;
    cnt_clr           = '0;
    cnt_inc[IDX_FUNC] = err_valid & ~bist_en_i;
    cnt_inc[IDX_BIST] = err_valid &  bist_en_i;
    cnt_clr[IDX_FUNC] = rd_en_i & (rd_sel_i == 1'(IDX_FUNC));
    cnt_clr[IDX_BIST] = bist_entry;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    bcrec_sat_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cnt_clr[g]),
      .inc_i   (cnt_inc[g]),
      .count_o (cnt[g])
    );
  end

  assign rd_data_o = rd_sel_i ? cnt[IDX_BIST] : cnt[IDX_FUNC];

  AST_NO_LINK_FUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_det_i && !rd_en_i) |=> $stable(cnt[IDX_FUNC])); // R2
  AST_FUNC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_en_i && !rd_en_i) |=> $stable(cnt[IDX_FUNC])); // R3
  AST_BIST_ENTRY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_en_i && !$past(bist_en_i) && !crc_err_i) |=> cnt[IDX_BIST] == '0); // R5
  AST_BIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bist_en_i |=> $stable(cnt[IDX_BIST])); // R6
  AST_BIST_RD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i && !err_valid && !bist_entry) |=> $stable(cnt[IDX_BIST])); // R10
endmodule

// File: tb/bcrec_top_test.sv
module bcrec_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       crc_err_i = 1'b0;
  logic       link_det_i = 1'b0;
  logic       bist_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       rd_sel_i = 1'b0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  bcrec_top uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .crc_err_i  (crc_err_i),
    .link_det_i (link_det_i),
    .bist_en_i  (bist_en_i),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .rd_data_o  (rd_data_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with given inputs, driven at negedge, returns just after posedge
  task automatic step(input logic err, input logic link, input logic bist,
                      input logic rd, input logic sel);
    @(negedge clk_i);
    crc_err_i = err; link_det_i = link; bist_en_i = bist; rd_en_i = rd; rd_sel_i = sel;
    @(posedge clk_i);
    #1;
  endtask

  // combinational peek, no clock edge
  task automatic peek(input logic sel, input string req, input logic [7:0] exp);
    @(negedge clk_i);
    crc_err_i = 1'b0; rd_en_i = 1'b0; rd_sel_i = sel;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic t_reset;
    peek(1'b0, "R1 func after reset", 8'd0);
    peek(1'b1, "R1 bist after reset", 8'd0);
  endtask

  task automatic t_func_count;
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0);
    peek(1'b0, "R3 func count 5", 8'd5);
    peek(1'b1, "R4 bist untouched in func mode", 8'd0);
  endtask

  task automatic t_no_link;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    peek(1'b0, "R2 func ignores strobe without link", 8'd5);
  endtask

  task automatic t_read_clear;
    @(negedge clk_i);
    crc_err_i = 0; link_det_i = 1; bist_en_i = 0; rd_en_i = 1; rd_sel_i = 0;
    #1 check("R8 read value during clear cycle", rd_data_o, 8'd5);
    @(posedge clk_i); #1;
    peek(1'b0, "R9 func cleared by read", 8'd0);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0);
    step(1, 1, 0, 1, 0);
    peek(1'b0, "R9 strobe with clearing read leaves 1", 8'd1);
  endtask

  task automatic t_bist_run;
    step(1, 1, 1, 0, 0);
    peek(1'b1, "R5 entry with strobe gives 1", 8'd1);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0);
    peek(1'b1, "R4 bist counts in bist", 8'd4);
    peek(1'b0, "R3 func frozen in bist", 8'd1);
    for (int i = 0; i < 2; i++) step(1, 0, 1, 0, 0);
    peek(1'b1, "R2 bist ignores strobe without link", 8'd4);
    step(0, 1, 1, 1, 1);
    peek(1'b1, "R10 bist read does not clear", 8'd4);
  endtask

  task automatic t_bist_exit;
    for (int i = 0; i < 2; i++) step(1, 1, 0, 0, 0);
    peek(1'b0, "R3 func resumes after exit", 8'd3);
    peek(1'b1, "R6 bist holds after exit", 8'd4);
    step(0, 1, 1, 0, 0);
    peek(1'b1, "R5 re-entry clears", 8'd0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 300; i++) step(1, 1, 1, 0, 0);
    peek(1'b1, "R7 bist saturates", 8'd255);
    for (int i = 0; i < 300; i++) step(1, 1, 0, 0, 0);
    peek(1'b0, "R7 func saturates", 8'd255);
    peek(1'b1, "R6 bist holds 255", 8'd255);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset;
    t_func_count;
    t_no_link;
    t_read_clear;
    t_bist_run;
    t_bist_exit;
    t_saturate;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule